// File: doc/BRIEF.md
# Low-Voltage Supervisor Status and Control Register

This block is an 8-bit status and control register for a supply supervisor. It receives two comparator results that are already synchronised to the bus clock. One reports that the supply has crossed a warning level and the other that it has crossed a detect level. It also receives a stop-mode indication and a single-cycle bus write strobe with its data byte. From these it keeps a sticky warning flag and a warning interrupt enable. It also keeps three configuration bits that can be written only once, which enable the detector, let a detect event reset the chip, and keep the detector running during stop. A reference-buffer enable completes the register.

The block drives four outputs: an interrupt request, a registered reset request, a detector enable for the analog side and the buffer enable. Software reads the register through `rdata_o` at any time. A write can acknowledge the warning flag and update the other writable fields in the same cycle. The warning flag does not clear while the supply is still below the warning level.

Top module: `lv_mon_ctrl`

## Requirements
- R1: Out of reset the register reads 0x1C. The bit positions are: bit 7 warning flag (read-only), bit 6 acknowledge (write-only, reads 0), bit 5 warning interrupt enable, bit 4 detect-reset enable, bit 3 detect-in-stop enable, bit 2 detect enable, bit 1 reserved (reads 0), bit 0 buffer enable.
- R2: Bits 4, 3 and 2 take their value from the first write after reset. One lock governs all three, and every later write leaves them unchanged.
- R3: Bits 5 and 0 take the written value on every write, and `buf_en_o` equals bit 0.
- R4: The warning flag becomes 1 on the clock after `warn_low_i` goes from 0 to 1. It also becomes 1 if `warn_low_i` is already 1 when reset ends. Once set, it stays 1 until it is acknowledged.
- R5: A write with bit 6 = 1 clears the warning flag on the next clock only if `warn_low_i` is 0 in that cycle. Otherwise the flag stays 1. The same write still updates the other writable bits.
- R6: `irq_o` is 1 exactly when the warning flag and bit 5 are both 1.
- R7: `rst_req_o` rises on the clock after `detect_low_i` is 1 while the detector is active (see R8) and bit 4 is 1. It then stays 1 until asynchronous reset.
- R8: `det_en_o` equals bit 2 AND (NOT `stop_mode_i` OR bit 3). Detect events are ignored whenever `det_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register read value |
| warn_low_i | input | 1 | Synchronised warning-level comparator, 1 = supply low |
| detect_low_i | input | 1 | Synchronised detect-level comparator, 1 = supply low |
| stop_mode_i | input | 1 | Chip is in stop mode |
| irq_o | output | 1 | Warning interrupt request |
| rst_req_o | output | 1 | Latched reset request to the reset sequencer |
| det_en_o | output | 1 | Detector enable after stop-mode gating |
| buf_en_o | output | 1 | Reference buffer enable |

## Verification
The assertions assume that both comparator inputs and the stop indication are synchronous to `clk_i` and change only between edges. They also assume that `wr_en_i` is a one-cycle strobe whose data is valid in that cycle. The stimulus drives every input on the falling edge from sequential tasks, so each value is stable at the rising edge that samples it. Warning pulses, acknowledges and stop transitions are placed one by one, with no glitches between clocks. Acknowledges are issued both while the warning input is held high and after it has dropped. The detector is exercised with stop asserted and deasserted under several lock-in configurations.

// File: rtl/lv_mon_pkg.sv
package lv_mon_pkg;
  localparam int REG_W  = 8;
  localparam int B_FLAG = 7;
  localparam int B_ACK  = 6;
  localparam int B_WIE  = 5;
  localparam int B_DRE  = 4;
  localparam int B_DSE  = 3;
  localparam int B_DE   = 2;
  localparam int B_BGE  = 0;
  localparam logic [REG_W-1:0] RST_VAL   = 8'h1C;
  localparam logic [REG_W-1:0] ONCE_MASK = 8'h1C;
  localparam logic [REG_W-1:0] RW_MASK   = 8'h21;
endpackage

// File: rtl/lv_mon_cfg.sv
module lv_mon_cfg #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    RSTV = '0,
  parameter logic [W-1:0]    ONCE = '0,
  parameter logic [W-1:0]    RW   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cfg_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   locked_q <= 1'b0;
    else if (wr_i) locked_q <= 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (ONCE[i]) begin : g_once
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                q <= RSTV[i];
        else if (wr_i && !locked_q) q <= wdata_i[i];
      end
      assign cfg_o[i] = q;
    end else if (RW[i]) begin : g_rw
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= RSTV[i];
        else if (wr_i) q <= wdata_i[i];
      end
      assign cfg_o[i] = q;
    end else begin : g_tie
      logic unused_bit;
      assign unused_bit = wdata_i[i];
      assign cfg_o[i]   = 1'b0;
    end
  end
endmodule

// File: rtl/lv_mon_flag.sv
module lv_mon_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warn_i,
  input  logic ack_i,
  output logic flag_o
);
  logic warn_q, rise;

  // warn_q resets low, so a level already high at reset exit looks like a rise
  assign rise = warn_i & ~warn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_q <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      warn_q <= warn_i;
      if (rise)                 flag_o <= 1'b1;
      else if (ack_i && !warn_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lv_mon_det.sv
module lv_mon_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic de_i,
  input  logic dse_i,
  input  logic dre_i,
  input  logic stop_i,
  input  logic det_low_i,
  output logic det_en_o,
  output logic rst_req_o
);
  assign det_en_o = de_i & (~stop_i | dse_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           rst_req_o <= 1'b0;
    else if (det_low_i && det_en_o && dre_i) rst_req_o <= 1'b1;
  end
endmodule

// File: rtl/lv_mon_ctrl.sv
module lv_mon_ctrl
  import lv_mon_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             warn_low_i,
  input  logic             detect_low_i,
  input  logic             stop_mode_i,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             det_en_o,
  output logic             buf_en_o
);
  logic [REG_W-1:0] cfg_q;
  logic             flag_q;
  logic             ack;

  assign ack = wr_en_i & wdata_i[B_ACK];

  lv_mon_cfg #(
    .W(REG_W), .RSTV(RST_VAL), .ONCE(ONCE_MASK), .RW(RW_MASK)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_en_i),
    .wdata_i(wdata_i), .cfg_o(cfg_q)
  );

  lv_mon_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .warn_i(warn_low_i),
    .ack_i(ack), .flag_o(flag_q)
  );

  lv_mon_det u_det (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .de_i(cfg_q[B_DE]), .dse_i(cfg_q[B_DSE]), .dre_i(cfg_q[B_DRE]),
    .stop_i(stop_mode_i), .det_low_i(detect_low_i),
    .det_en_o(det_en_o), .rst_req_o(rst_req_o)
  );

  always_comb begin
    rdata_o         = cfg_q;
    rdata_o[B_FLAG] = flag_q;
  end

  assign irq_o    = flag_q & cfg_q[B_WIE];
  assign buf_en_o = cfg_q[B_BGE];
endmodule

// File: rtl/lv_mon_chk.sv
module lv_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       warn_low_i,
  input logic       detect_low_i,
  input logic       stop_mode_i,
  input logic       irq_o,
  input logic       rst_req_o,
  input logic       det_en_o,
  input logic       buf_en_o
);
  logic seen_wr;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_wr <= 1'b0;
    else if (wr_en_i) seen_wr <= 1'b1;
  end

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[6] == 1'b0) && (rdata_o[1] == 1'b0));

  p_once_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_wr && wr_en_i) |=> $stable(rdata_o[4:2]));

  p_buf_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_en_o == rdata_o[0]);

  p_flag_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warn_low_i) |=> rdata_o[7]);

  p_ack_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[7] && wr_en_i && wdata_i[6] && warn_low_i) |=> rdata_o[7]);

  p_ack_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i[6] && !warn_low_i) |=> !rdata_o[7]);

  p_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (rdata_o[7] && rdata_o[5]));

  p_rreq_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  p_rreq_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(detect_low_i && det_en_o && rdata_o[4]));

  p_stop_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_mode_i && !rdata_o[3]) |-> !det_en_o);
endmodule

bind lv_mon_ctrl lv_mon_chk u_chk (.*);

// File: tb/sim_lv_mon_ctrl.sv
`timescale 1ns/1ps
module sim_lv_mon_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       warn = 1'b0, det = 1'b0, stop = 1'b0;
  logic       irq, rreq, den, buf_en;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  lv_mon_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .warn_low_i(warn), .detect_low_i(det),
    .stop_mode_i(stop), .irq_o(irq), .rst_req_o(rreq),
    .det_en_o(den), .buf_en_o(buf_en)
  );

  // behavioural reference state
  bit m_flag, m_prev, m_wie, m_bge, m_dre, m_dse, m_de, m_lock, m_rreq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag <= 0; m_prev <= 0; m_wie <= 0; m_bge <= 0;
      m_dre <= 1; m_dse <= 1; m_de <= 1; m_lock <= 0; m_rreq <= 0;
    end else begin
      m_prev <= warn;
      if (warn && !m_prev) m_flag <= 1;
      else if (wr_en && wdata[6] && !warn) m_flag <= 0;
      if (wr_en) begin
        m_wie <= wdata[5];
        m_bge <= wdata[0];
        m_lock <= 1;
        if (!m_lock) begin
          m_dre <= wdata[4]; m_dse <= wdata[3]; m_de <= wdata[2];
        end
      end
      if (det && m_dre && m_de && (!stop || m_dse)) m_rreq <= 1;
    end
  end

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      check("R4/R5 flag", {7'd0, rdata[7]}, {7'd0, m_flag});
      check("R2 once bits", {5'd0, rdata[4:2]}, {5'd0, m_dre, m_dse, m_de});
      check("R3 rw bits", {6'd0, rdata[5], rdata[0]}, {6'd0, m_wie, m_bge});
      check("R1 reserved", {6'd0, rdata[6], rdata[1]}, 8'd0);
      check("R3 buf_en", {7'd0, buf_en}, {7'd0, m_bge});
      check("R6 irq", {7'd0, irq}, {7'd0, m_flag & m_wie});
      check("R7 rst_req", {7'd0, rreq}, {7'd0, m_rreq});
      check("R8 det_en", {7'd0, den}, {7'd0, m_de & (!stop | m_dse)});
    end
  end

  task automatic do_reset(bit warn_at_exit);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; det = 0; stop = 0; warn = warn_at_exit;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset value
    do_reset(0);
    idle(1);
    check("R1 reset value", rdata, 8'h1C);
    check("R7 no reset request after reset", {7'd0, rreq}, 8'd0);

    // R4 warning already low at reset exit
    do_reset(1);
    idle(2);
    check("R4 flag set at reset exit", {7'd0, rdata[7]}, 8'd1);
    // R5 ack while warning present: flag stays, wie and bge still updated
    wr(8'h61);
    check("R5 ack blocked while low", {7'd0, rdata[7]}, 8'd1);
    check("R5 same write updates wie/bge", {6'd0, rdata[5], rdata[0]}, 8'd3);
    check("R6 irq asserted", {7'd0, irq}, 8'd1);
    check("R2 first write took once bits", {5'd0, rdata[4:2]}, 8'd0);
    // R5 ack after warning drops
    @(negedge clk); warn = 0;
    idle(2);
    check("R5 flag sticky after warn drop", {7'd0, rdata[7]}, 8'd1);
    wr(8'h40);
    check("R5 ack clears flag", {7'd0, rdata[7]}, 8'd0);
    check("R6 irq low after clear", {7'd0, irq}, 8'd0);
    // R2 later write ignored for once bits
    wr(8'h1D);
    check("R2 once bits ignored after lock", {5'd0, rdata[4:2]}, 8'd0);
    check("R3 bge written again", {7'd0, buf_en}, 8'd1);
    // R8 detector disabled: detect has no effect
    @(negedge clk); det = 1;
    idle(3);
    check("R7 no request with detect disabled", {7'd0, rreq}, 8'd0);
    @(negedge clk); det = 0;

    // R4 rising edge sets flag, R6 with wie
    do_reset(0);
    wr(8'h3C);
    @(negedge clk); warn = 1;
    idle(1);
    check("R4 flag set on rise", {7'd0, rdata[7]}, 8'd1);
    check("R6 irq on rise", {7'd0, irq}, 8'd1);
    @(negedge clk); warn = 0;
    idle(2);
    @(negedge clk); warn = 1;
    idle(2);
    @(negedge clk); warn = 0;

    // R8 stop gating and R7 reset request
    do_reset(0);
    wr(8'h14);                       // de=1, dre=1, dse=0
    @(negedge clk); stop = 1;
    #1 check("R8 det_en masked in stop", {7'd0, den}, 8'd0);
    @(negedge clk); det = 1;
    idle(3);
    check("R7 detect masked during stop", {7'd0, rreq}, 8'd0);
    @(negedge clk); stop = 0;
    #1 check("R8 det_en out of stop", {7'd0, den}, 8'd1);
    idle(1);
    check("R7 request raised", {7'd0, rreq}, 8'd1);
    @(negedge clk); det = 0;
    idle(3);
    check("R7 request held", {7'd0, rreq}, 8'd1);

    // R8 stop with dse=1 keeps detector; dre=0 blocks request
    do_reset(0);
    wr(8'h0C);                       // dre=0, dse=1, de=1
    @(negedge clk); stop = 1;
    #1 check("R8 det_en kept in stop", {7'd0, den}, 8'd1);
    @(negedge clk); det = 1;
    idle(3);
    check("R7 no request with dre=0", {7'd0, rreq}, 8'd0);
    @(negedge clk); det = 0; stop = 0;

    // R7 default enables, detect in stop with dse=1
    do_reset(0);
    @(negedge clk); stop = 1; det = 1;
    idle(2);
    check("R7 default request in stop", {7'd0, rreq}, 8'd1);
    @(negedge clk); det = 0; stop = 0;
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule